// File: doc/BRIEF.md
# Fixed-Latency AES Substitution Coprocessor

This unit sits beside a processor core. It gives the core a private AES byte-substitution step that always takes the same time. The core loads a 128-bit AES state and a 32-bit round-key word into registers inside the unit. It then issues a start. The unit replaces all sixteen state bytes with their forward S-box images in parallel, and it folds the round-key word into one chosen state word. Software reads the result back one 32-bit word at a time. MixColumns, ShiftRows and key expansion stay in software.

The S-box is not a lookup table in memory. It is computed from logic: a multiplicative inverse in GF(2^8), then the affine map. The inverse is registered, and the affine map and key mix are applied in the following cycle. Every substitution therefore takes exactly two cycles, whatever the data or key. No data memory or data cache is ever touched, so there is no timing channel from cache misses.

Top module: `sbox_coproc`

## Requirements
- R1: While `rst` is high at a clock edge, the state, the key register, `rd_data`, `busy` and `done` are all cleared to zero.
- R2: When `wr_state_en` is high and the unit is not busy, the whole state is loaded from `wr_state_data`. State word w is bits [32w+31:32w], and state byte b is bits [8b+7:8b]. A full load takes priority over a word write in the same cycle.
- R3: When `wr_word_en` is high, `wr_state_en` is low and the unit is not busy, `wr_word_data` replaces the state word selected by `word_sel`. The other three words are unchanged.
- R4: `key_wr_en` loads `key_data` into the round-key register. Without it, the register holds its value.
- R5: `rd_data` is registered. It shows the state word selected by `rd_sel` one cycle after `rd_sel` is presented.
- R6: On an accepted start, every state byte x is replaced by S(x). S(x) takes the inverse of x in GF(2^8) modulo x^8+x^4+x^3+x+1, with 0 mapped to 0, then applies the affine map. In that map, output bit i is the XOR of input bits i, i+4, i+5, i+6 and i+7 (taken mod 8) and bit i of 0x63. For example, S(0x00)=0x63 and S(0x53)=0xED.
- R7: The round-key register is XORed into the state word selected by `word_sel` in the start cycle. The other three words receive the bare S-box result.
- R8: If start is accepted in cycle c, `busy` is high in cycle c+1 only. `done` is a single-cycle pulse in cycle c+2, and the new state is in place from that cycle. The same timing holds for every data and key value.
- R9: While `busy` is high, `start`, `wr_state_en` and `wr_word_en` are ignored. No second operation follows, and the result is not overwritten.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_state_en | input | 1 | Load the full 128-bit state |
| wr_state_data | input | 128 | Full state value |
| wr_word_en | input | 1 | Write one state word |
| word_sel | input | 2 | Word targeted by a word write, or by the key mix at start |
| wr_word_data | input | 32 | Word write value |
| key_wr_en | input | 1 | Load the round-key register |
| key_data | input | 32 | Round-key word |
| start | input | 1 | Begin a substitution |
| rd_sel | input | 2 | Word chosen for readback |
| rd_data | output | 32 | Registered readback word |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Result ready pulse |

## Verification
The assertions check the timing on every cycle:
- a start leads to exactly one busy cycle and then one done pulse;
- done never appears without a start two cycles earlier;
- busy and done are never high together;
- the key register and the idle state never change without a write.

The S-box values, the position of the key mix and the readback word order can only be shown by the bench's scenarios. The bench pushes all 256 byte values through the unit and compares each result against an S-box it builds itself from log and antilog tables. It also exercises write priority and the inputs that are ignored while busy.

// File: rtl/sbox_pkg.sv
package sbox_pkg;
  localparam int BYTE_W = 8;
  localparam logic [7:0] AFFINE_C = 8'h63;
  localparam logic [7:0] REDUCE_P = 8'h1b;

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] sh;
    acc = '0;
    sh = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = {sh[6:0], 1'b0} ^ (sh[7] ? REDUCE_P : 8'h00);
    end
    return acc;
  endfunction
endpackage

// File: rtl/gf_inv8.sv
module gf_inv8
  import sbox_pkg::*;
(
  input  logic [BYTE_W-1:0] a,
  output logic [BYTE_W-1:0] y
);
  // x^254 = product of x^(2^k), k = 1..7; maps 0 to 0
  always_comb begin
    logic [7:0] sq;
    logic [7:0] acc;
    sq = a;
    acc = 8'h01;
    for (int k = 1; k < 8; k++) begin
      sq = gf_mul(sq, sq);
      acc = gf_mul(acc, sq);
    end
    y = acc;
  end
endmodule

// File: rtl/sbox_affine8.sv
module sbox_affine8
  import sbox_pkg::*;
(
  input  logic [BYTE_W-1:0] a,
  output logic [BYTE_W-1:0] y
);
  genvar i;
  generate
    for (i = 0; i < BYTE_W; i++) begin : g_bit
      assign y[i] = a[i] ^ a[(i+4)%8] ^ a[(i+5)%8] ^ a[(i+6)%8] ^ a[(i+7)%8] ^ AFFINE_C[i];
    end
  endgenerate
endmodule

// File: rtl/sbox_coproc.sv
module sbox_coproc
  import sbox_pkg::*;
#(
  parameter int STATE_W = 128,
  parameter int WORD_W  = 32,
  localparam int NWORDS = STATE_W / WORD_W,
  localparam int NBYTES = STATE_W / BYTE_W,
  localparam int SEL_W  = $clog2(NWORDS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_state_en,
  input  logic [STATE_W-1:0] wr_state_data,
  input  logic               wr_word_en,
  input  logic [SEL_W-1:0]   word_sel,
  input  logic [WORD_W-1:0]  wr_word_data,
  input  logic               key_wr_en,
  input  logic [WORD_W-1:0]  key_data,
  input  logic               start,
  input  logic [SEL_W-1:0]   rd_sel,
  output logic [WORD_W-1:0]  rd_data,
  output logic               busy,
  output logic               done
);
  logic [STATE_W-1:0] state_q, inv_q, inv_d, sub_d, keyed_d;
  logic [WORD_W-1:0]  key_q, rd_q;
  logic [SEL_W-1:0]   tgt_q;
  logic               busy_q, done_q;
  logic               go;

  assign go = start && !busy_q;

  genvar b, w;
  generate
    for (b = 0; b < NBYTES; b++) begin : g_lane
      gf_inv8 u_inv (.a(state_q[b*BYTE_W +: BYTE_W]), .y(inv_d[b*BYTE_W +: BYTE_W]));
      sbox_affine8 u_aff (.a(inv_q[b*BYTE_W +: BYTE_W]), .y(sub_d[b*BYTE_W +: BYTE_W]));
    end
    for (w = 0; w < NWORDS; w++) begin : g_word
      assign keyed_d[w*WORD_W +: WORD_W] = sub_d[w*WORD_W +: WORD_W]
                                         ^ ((tgt_q == SEL_W'(w)) ? key_q : '0);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= '0;
      inv_q   <= '0;
      key_q   <= '0;
      rd_q    <= '0;
      tgt_q   <= '0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      busy_q <= go;
      done_q <= busy_q;
      if (go) begin
        inv_q <= inv_d;
        tgt_q <= word_sel;
      end
      if (busy_q) state_q <= keyed_d;
      else if (wr_state_en) state_q <= wr_state_data;
      else if (wr_word_en) state_q[int'(word_sel)*WORD_W +: WORD_W] <= wr_word_data;
      if (key_wr_en) key_q <= key_data;
      rd_q <= state_q[int'(rd_sel)*WORD_W +: WORD_W];
    end
  end

  assign rd_data = rd_q;
  assign busy    = busy_q;
  assign done    = done_q;

  p_busy_after_start_r8: assert property (@(posedge clk) disable iff (rst)
    go |=> (busy_q && !done_q));
  p_done_after_busy_r8: assert property (@(posedge clk) disable iff (rst)
    busy_q |=> (done_q && !busy_q));
  p_done_origin_r8: assert property (@(posedge clk) disable iff (rst)
    done_q |-> $past(go, 2));
  p_flags_excl_r8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({busy_q, done_q}));
  p_key_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !key_wr_en |=> $stable(key_q));
  p_state_idle_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!busy_q && !wr_state_en && !wr_word_en) |=> $stable(state_q));
endmodule

// File: tb/tb_sbox_coproc.sv
`timescale 1ns/1ps
module tb_sbox_coproc;
  logic clk = 0, rst = 1;
  logic wr_state_en = 0, wr_word_en = 0, key_wr_en = 0, start = 0;
  logic [127:0] wr_state_data = '0;
  logic [1:0] word_sel = 0, rd_sel = 0;
  logic [31:0] wr_word_data = '0, key_data = '0, rd_data;
  logic busy, done;
  int checks = 0, fails = 0;
  logic [7:0] alog [256];
  logic [7:0] lg [256];
  logic [7:0] sb [256];

  always #2.5 clk = ~clk;

  sbox_coproc dut (.clk(clk), .rst(rst), .wr_state_en(wr_state_en), .wr_state_data(wr_state_data),
    .wr_word_en(wr_word_en), .word_sel(word_sel), .wr_word_data(wr_word_data),
    .key_wr_en(key_wr_en), .key_data(key_data), .start(start), .rd_sel(rd_sel),
    .rd_data(rd_data), .busy(busy), .done(done));

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick; @(negedge clk); endtask

  task automatic read_word(input int w, output logic [31:0] v);
    rd_sel = 2'(w); tick; v = rd_data;
  endtask

  function automatic logic [31:0] exp_word(input logic [127:0] st, input int w, input int sel, input logic [31:0] k);
    logic [31:0] r;
    for (int b = 0; b < 4; b++) r[b*8 +: 8] = sb[st[(w*4+b)*8 +: 8]];
    return (w == sel) ? (r ^ k) : r;
  endfunction

  task automatic load_state(input logic [127:0] v);
    wr_state_en = 1; wr_state_data = v; tick; wr_state_en = 0;
  endtask

  task automatic set_key(input logic [31:0] k);
    key_wr_en = 1; key_data = k; tick; key_wr_en = 0;
  endtask

  task automatic run(input int sel);
    start = 1; word_sel = 2'(sel); tick; start = 0;
    chk("R8 busy", {126'd0, busy, done}, 128'b10);
    tick;
    chk("R8 done", {126'd0, busy, done}, 128'b01);
  endtask

  task automatic verify(input logic [127:0] st, input int sel, input logic [31:0] k, input string tag);
    logic [31:0] v;
    for (int w = 0; w < 4; w++) begin
      read_word(w, v);
      chk(tag, v, exp_word(st, w, sel, k));
    end
  endtask

  initial begin
    logic [7:0] t;
    logic [127:0] st;
    logic [31:0] v;
    t = 8'h01;
    for (int i = 0; i < 255; i++) begin
      alog[i] = t; lg[t] = 8'(i);
      t = t ^ ({t[6:0], 1'b0} ^ (t[7] ? 8'h1b : 8'h00));
    end
    for (int x = 0; x < 256; x++) begin
      logic [7:0] inv, s;
      inv = (x == 0) ? 8'h00 : alog[(255 - int'(lg[x])) % 255];
      s = inv ^ {inv[6:0], inv[7]} ^ {inv[5:0], inv[7:6]} ^ {inv[4:0], inv[7:5]} ^ {inv[3:0], inv[7:4]} ^ 8'h63;
      sb[x] = s;
    end
    chk("R6 table 00", sb[0], 8'h63);
    chk("R6 table 53", sb[8'h53], 8'hed);

    tick; tick;
    chk("R1 reset flags", {126'd0, busy, done}, 128'd0);
    chk("R1 reset rd", rd_data, 0);
    rst = 0;
    for (int w = 0; w < 4; w++) begin read_word(w, v); chk("R1 state zero", v, 0); end

    // R2 full load with word index ordering, priority over word write
    st = 128'h33333333_22222222_11111111_00000000;
    wr_word_en = 1; wr_word_data = 32'hdeadbeef; word_sel = 1;
    load_state(st); wr_word_en = 0;
    for (int w = 0; w < 4; w++) begin read_word(w, v); chk("R2 load", v, {4{8'(w * 8'h11)}}); end

    // R3 word write
    wr_word_en = 1; word_sel = 2; wr_word_data = 32'hcafef00d; tick; wr_word_en = 0;
    st[64 +: 32] = 32'hcafef00d;
    for (int w = 0; w < 4; w++) begin read_word(w, v); chk("R3 word write", v, st[w*32 +: 32]); end

    // R4 key load, R6/R7/R8 exhaustive sweep across all byte values
    for (int g = 0; g < 16; g++) begin
      logic [31:0] k;
      k = 32'h01020304 * (g + 1) ^ 32'h5a5aa5a5;
      set_key(k);
      for (int b = 0; b < 16; b++) st[b*8 +: 8] = 8'(g*16 + b);
      load_state(st);
      run(g % 4);
      verify(st, g % 4, k, "R6 R7 sweep");
    end

    // R7 zero key: pure substitution in every word
    set_key(0);
    st = 128'h0053_00ff_1234_5678_9abc_def0_0f1e_2d3c;
    load_state(st); run(3); verify(st, 3, 0, "R6 R4 zero key");

    // R9 inputs ignored while busy
    set_key(32'h11223344);
    st = 128'h00112233_44556677_8899aabb_ccddeeff;
    load_state(st);
    start = 1; word_sel = 0; tick;
    wr_state_en = 1; wr_state_data = '1; wr_word_en = 1; wr_word_data = 32'h0;
    chk("R9 busy", busy, 1);
    tick;
    start = 0; wr_state_en = 0; wr_word_en = 0;
    chk("R9 done", done, 1);
    tick;
    chk("R9 no second op", {126'd0, busy, done}, 128'd0);
    tick;
    chk("R9 no second done", done, 0);
    verify(st, 0, 32'h11223344, "R9 result kept");

    // R5 readback latency: new rd_sel shows one cycle later
    rd_sel = 2; tick;
    chk("R5 latency", rd_data, exp_word(st, 2, 0, 32'h11223344));

    // R1 reset mid-use
    rst = 1; tick; rst = 0;
    chk("R1 reset again", rd_data, 0);
    for (int w = 0; w < 4; w++) begin read_word(w, v); chk("R1 state cleared", v, 0); end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule